// File: doc/BRIEF.md
# Falling-Edge Pin Interrupt Port

This block watches one 8-bit input port and raises an interrupt request when any enabled pin falls. Each pin is passed through a synchroniser. A high-to-low change seen on the synchronised value sets a sticky per-pin flag. The flag stays set until software writes a one to it. Writing a zero to a flag does nothing.

Two 8-bit control registers shape this behaviour. The input-enable register decides which pins take part in edge detection at all. The interrupt-mask register decides which of the pending flags reach the single combined request line. Masking a pin hides its flag from the request, but the flag itself is kept.

Software reaches all three registers over a small register bus. A write is taken on the clock edge while select and write-enable are both high. Read data is combinational from the address.

Top module: `edge_irq_port`

## Requirements
- R1: After reset, the input-enable register, the interrupt-mask register and the flag register all read 0, and `irq_o` is 0.
- R2: When a pin with input enable 1 goes from 1 to 0, its flag bit reads 1 from the third rising clock edge after the pin change. The pin passes through two synchroniser flops and an edge register on the way.
- R3: A rising edge on a pin never sets its flag. A pin that stays at one level never sets its flag.
- R4: Writing to offset 2 clears exactly the flag bits written as 1. Flag bits written as 0 keep their value.
- R5: When a falling edge on a pin is detected on the same clock edge as a write-1 clear of that pin's flag, the flag ends up 1.
- R6: An interrupt-mask bit of 0 keeps its flag out of `irq_o`, but the flag stays set and can still be read.
- R7: `irq_o` is 1 exactly when at least one flag bit and its matching interrupt-mask bit are both 1.
- R8: A falling edge on a pin whose input-enable bit is 0 does not set the flag. Setting the input-enable bit while the pin is already low also does not set the flag.
- R9: Address map: offset 0 is input enable, offset 1 is interrupt mask, offset 2 is flags. Offset 3 reads as 0, and writes to it change nothing.
- R10: The input-enable and interrupt-mask registers read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_i | input | 8 | Asynchronous port pins |
| bus_sel_i | input | 1 | Register access select |
| bus_we_i | input | 1 | Write strobe, taken when selected |
| bus_addr_i | input | 2 | Register offset |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data of the addressed register |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench targets a clear that lands on the same edge as a new fall on that pin. A design that lets the clear win would lose that interrupt, and the flag would read 0. It also disables a pin's input while the pin falls, and then enables it while the pin is held low. A design that gates the pin value itself would take the disable or enable as a fake edge and set a stray flag. Finally, it masks a pending flag and later unmasks it. A design that clears on mask, or ignores the mask, would either drop the flag or drive `irq_o` while the flag is masked.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;
  // register offsets on the access bus
  localparam int unsigned OFS_DIN  = 0;
  localparam int unsigned OFS_IE   = 1;
  localparam int unsigned OFS_FLAG = 2;

  typedef struct packed {
    logic din;
    logic ie;
    logic flag;
  } wr_sel_t;
endpackage

// File: rtl/eip_rst_sync.sv
module eip_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_core_n = sh_q[STAGES-1];
endmodule

// File: rtl/eip_pin_sync.sv
module eip_pin_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_async,
  output logic [WIDTH-1:0] pin_sync
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb begin
      chain_d = {chain_q[STAGES-2:0], pin_async[g]};
    end

    // idle level is high so a released reset never looks like a fall
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= chain_d;
    end

    assign pin_sync[g] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/eip_edge_flags.sv
module eip_edge_flags #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_sync,
  input  logic [WIDTH-1:0] din_en,
  input  logic [WIDTH-1:0] clr_mask,
  output logic [WIDTH-1:0] fall,
  output logic [WIDTH-1:0] flags
);
  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] flags_q;
  logic [WIDTH-1:0] flags_d;

  // qualify the edge rather than the level: toggling the enable never fakes a fall
  always_comb begin
    fall    = prev_q & ~pin_sync & din_en;
    flags_d = (flags_q & ~clr_mask) | fall;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '1;
      flags_q <= '0;
    end else begin
      prev_q  <= pin_sync;
      flags_q <= flags_d;
    end
  end

  assign flags = flags_q;
endmodule

// File: rtl/eip_regbus.sv
module eip_regbus
  import edge_irq_pkg::*;
#(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wdata,
  input  logic [WIDTH-1:0]  flags,
  output logic [WIDTH-1:0]  rdata,
  output logic [WIDTH-1:0]  din_en,
  output logic [WIDTH-1:0]  irq_en,
  output logic [WIDTH-1:0]  clr_mask
);
  localparam logic [ADDR_W-1:0] A_DIN  = ADDR_W'(OFS_DIN);
  localparam logic [ADDR_W-1:0] A_IE   = ADDR_W'(OFS_IE);
  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(OFS_FLAG);

  wr_sel_t          wr;
  logic [WIDTH-1:0] din_q, din_d;
  logic [WIDTH-1:0] ie_q, ie_d;

  always_comb begin
    wr.din  = sel && we && (addr == A_DIN);
    wr.ie   = sel && we && (addr == A_IE);
    wr.flag = sel && we && (addr == A_FLAG);
  end

  always_comb begin
    din_d = din_q;
    ie_d  = ie_q;
    if (wr.din) din_d = wdata;
    if (wr.ie)  ie_d  = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      din_q <= '0;
      ie_q  <= '0;
    end else begin
      din_q <= din_d;
      ie_q  <= ie_d;
    end
  end

  assign clr_mask = wr.flag ? wdata : '0;
  assign din_en   = din_q;
  assign irq_en   = ie_q;

  always_comb begin
    if      (addr == A_DIN)  rdata = din_q;
    else if (addr == A_IE)   rdata = ie_q;
    else if (addr == A_FLAG) rdata = flags;
    else                     rdata = '0;
  end
endmodule

// File: rtl/edge_irq_port.sv
module edge_irq_port #(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WIDTH-1:0]  pin_i,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [WIDTH-1:0]  bus_wdata_i,
  output logic [WIDTH-1:0]  bus_rdata_o,
  output logic              irq_o
);
  logic             rst_core_n;
  logic [WIDTH-1:0] pin_s;
  logic [WIDTH-1:0] din_en;
  logic [WIDTH-1:0] irq_en;
  logic [WIDTH-1:0] clr_mask;
  logic [WIDTH-1:0] fall;
  logic [WIDTH-1:0] flags;

  eip_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  eip_pin_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .pin_async (pin_i),
    .pin_sync  (pin_s)
  );

  eip_edge_flags #(.WIDTH(WIDTH)) u_flags (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .pin_sync (pin_s),
    .din_en   (din_en),
    .clr_mask (clr_mask),
    .fall     (fall),
    .flags    (flags)
  );

  eip_regbus #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_bus (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .sel      (bus_sel_i),
    .we       (bus_we_i),
    .addr     (bus_addr_i),
    .wdata    (bus_wdata_i),
    .flags    (flags),
    .rdata    (bus_rdata_o),
    .din_en   (din_en),
    .irq_en   (irq_en),
    .clr_mask (clr_mask)
  );

  assign irq_o = |(flags & irq_en);
endmodule

// File: rtl/edge_irq_port_chk.sv
module edge_irq_port_chk #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel,
  input logic              we,
  input logic [ADDR_W-1:0] addr,
  input logic [WIDTH-1:0]  wdata,
  input logic [WIDTH-1:0]  rdata,
  input logic              irq,
  input logic [WIDTH-1:0]  flags,
  input logic [WIDTH-1:0]  ie,
  input logic [WIDTH-1:0]  din,
  input logic [WIDTH-1:0]  fall
);
  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_HOLE = ADDR_W'(3);

  logic flag_wr;
  assign flag_wr = sel && we && (addr == A_FLAG);

  a_r3_no_set_without_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (fall == '0) |=> ((flags & ~$past(flags)) == '0));

  a_r4_clear_only_written: assert property (@(posedge clk) disable iff (!rst_n)
    flag_wr |=> (($past(flags) & ~flags & ~$past(wdata)) == '0));

  a_r5_fall_always_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (fall != '0) |=> ((flags & $past(fall)) == $past(fall)));

  a_r6_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_wr |=> (($past(flags) & ~flags) == '0));

  a_r7_irq_needs_enabled_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((flags & ie) != '0));

  a_r7_enabled_flag_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags & ie) != '0) |-> irq);

  a_r8_disabled_pin_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    (din != '1) |=> ((flags & ~$past(flags) & ~$past(din)) == '0));

  a_r9_hole_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == A_HOLE) |-> (rdata == '0));
endmodule

bind edge_irq_port edge_irq_port_chk #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_chk (
  .clk   (clk),
  .rst_n (rst_core_n),
  .sel   (bus_sel_i),
  .we    (bus_we_i),
  .addr  (bus_addr_i),
  .wdata (bus_wdata_i),
  .rdata (bus_rdata_o),
  .irq   (irq_o),
  .flags (flags),
  .ie    (irq_en),
  .din   (din_en),
  .fall  (fall)
);

// File: tb/edge_irq_port_test.sv
`timescale 1ns/1ps
module edge_irq_port_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pins = 8'hFF;
  logic       sel = 1'b0;
  logic       we = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq;

  int tests = 0;
  int fails = 0;
  bit started = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  edge_irq_port uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .pin_i       (pins),
    .bus_sel_i   (sel),
    .bus_we_i    (we),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .irq_o       (irq)
  );

  // behavioural reference: history of pin samples and register images
  logic [7:0] m_den, m_ie, m_flag;
  logic [7:0] hist[$];

  always @(posedge clk) begin
    logic [7:0] f, c;
    if (!rst_n) begin
      m_den = 8'h00; m_ie = 8'h00; m_flag = 8'h00;
      hist = '{8'hFF, 8'hFF, 8'hFF};
    end else begin
      f = hist[2] & ~hist[1] & m_den;
      c = (sel && we && addr == 2'd2) ? wdata : 8'h00;
      m_flag = (m_flag & ~c) | f;
      if (sel && we && addr == 2'd0) m_den = wdata;
      if (sel && we && addr == 2'd1) m_ie = wdata;
      hist.push_front(pins);
      void'(hist.pop_back());
    end
  end

  function automatic logic [7:0] m_read(input logic [1:0] a);
    case (a)
      2'd0: return m_den;
      2'd1: return m_ie;
      2'd2: return m_flag;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model, one step after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (started && !done) begin
        check("R7 model irq", {7'd0, irq}, {7'd0, |(m_flag & m_ie)});
        check("R9 model rdata", rdata, m_read(addr));
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    addr = a; sel = 1'b1; we = 1'b0;
    #1;
    check(tag, rdata, exp);
    sel = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_pins(input logic [7:0] v);
    @(negedge clk);
    pins = v;
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    #1;
    check(tag, {7'd0, irq}, {7'd0, exp});
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(4);
    started = 1'b1;

    rd(2'd0, 8'h00, "R1 din reset");
    rd(2'd1, 8'h00, "R1 ie reset");
    rd(2'd2, 8'h00, "R1 flag reset");
    chk_irq(1'b0, "R1 irq reset");

    wr(2'd0, 8'hFF);
    wr(2'd1, 8'h00);
    rd(2'd0, 8'hFF, "R10 din readback");
    rd(2'd1, 8'h00, "R10 ie readback");

    set_pins(8'hFE);
    idle(4);
    rd(2'd2, 8'h01, "R2 fall sets flag0");
    chk_irq(1'b0, "R6 masked flag no irq");

    set_pins(8'hFF);
    idle(4);
    rd(2'd2, 8'h01, "R3 rise sets nothing");

    wr(2'd1, 8'h01);
    chk_irq(1'b1, "R7 unmask raises irq");
    wr(2'd2, 8'hFE);
    rd(2'd2, 8'h01, "R4 zero write keeps flag");
    wr(2'd2, 8'h01);
    rd(2'd2, 8'h00, "R4 one write clears");
    chk_irq(1'b0, "R7 irq drops after clear");

    wr(2'd0, 8'hFD);
    set_pins(8'hFD);
    idle(4);
    rd(2'd2, 8'h00, "R8 disabled pin fall ignored");
    set_pins(8'hFF);
    idle(4);
    set_pins(8'hFD);
    idle(4);
    wr(2'd0, 8'hFF);
    idle(4);
    rd(2'd2, 8'h00, "R8 enable while low no flag");
    set_pins(8'hFF);
    idle(4);
    rd(2'd2, 8'h00, "R3 rise after enable no flag");

    set_pins(8'hFB);
    idle(4);
    rd(2'd2, 8'h04, "R2 fall sets flag2");
    set_pins(8'hFF);
    idle(4);
    set_pins(8'hFB);
    idle(1);
    wr(2'd2, 8'h04);
    rd(2'd2, 8'h04, "R5 edge beats clear");
    wr(2'd2, 8'h04);
    rd(2'd2, 8'h00, "R4 clear without edge");
    set_pins(8'hFF);
    idle(4);

    wr(2'd1, 8'h10);
    set_pins(8'h6F);
    idle(4);
    rd(2'd2, 8'h90, "R2 two pins fall together");
    chk_irq(1'b1, "R7 one enabled flag");
    wr(2'd2, 8'h10);
    rd(2'd2, 8'h80, "R6 masked flag kept");
    chk_irq(1'b0, "R6 masked flag no irq");
    wr(2'd1, 8'h80);
    chk_irq(1'b1, "R6 unmask pending flag");

    wr(2'd3, 8'hFF);
    rd(2'd3, 8'h00, "R9 hole reads zero");
    rd(2'd0, 8'hFF, "R9 din untouched");
    rd(2'd1, 8'h80, "R9 ie untouched");
    rd(2'd2, 8'h80, "R9 flags untouched");
    wr(2'd2, 8'hFF);
    rd(2'd2, 8'h00, "R4 clear all");
    chk_irq(1'b0, "R7 idle after clear");

    idle(2);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule